// File: doc/BRIEF.md
# Sign-Magnitude Integer Adder/Subtractor

This unit adds or subtracts two W-bit integers held in sign-magnitude form. The top bit of each word is the sign and the lower W-1 bits are an unsigned binary magnitude. The representable range is symmetric, from -(2^(W-1)-1) to +(2^(W-1)-1), and zero has two encodings.

Subtraction flips the sign of the second operand and then takes the addition path. When the effective signs agree, the magnitudes are summed under the common sign. When they disagree, a magnitude comparator picks the larger operand, the smaller magnitude is subtracted from it, and the result takes the larger operand's sign.

Each operation is captured on a clock edge when its input strobe is high. The result, a flag marking a valid result, and an overflow flag appear one cycle later. A zero result is always emitted as positive zero.

Top module: `sm_addsub`

## Requirements
- R1: Operand and result words use bit W-1 as the sign (0 non-negative, 1 negative) and bits W-2..0 as an unsigned magnitude; `sub_i`=0 selects a+b and `sub_i`=1 selects a-b.
- R2: When the effective signs agree and the magnitude sum fits in W-1 bits, the result magnitude is the sum and the result sign is the common sign.
- R3: `ovf_o` is 1 exactly when the effective signs agree and the magnitude sum exceeds 2^(W-1)-1; the result magnitude is then the low W-1 bits of that sum, under the common sign.
- R4: When the effective signs differ, the result magnitude is the larger magnitude minus the smaller, the sign is that of the larger-magnitude operand, and `ovf_o` is 0.
- R5: Subtraction gives the same result as adding `b_i` with its sign bit inverted.
- R6: An input with sign 1 and zero magnitude behaves exactly like an input of positive zero.
- R7: Any result with zero magnitude is output with sign 0.
- R8: An operation presented with `in_vld_i`=1 appears on `res_o`/`ovf_o` with `out_vld_o`=1 one clock later; in a cycle after `in_vld_i`=0, `out_vld_o` is 0 and `res_o`/`ovf_o` keep their previous values.
- R9: While `rst_n` is low, `out_vld_o`, `res_o` and `ovf_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld_i | input | 1 | Operation strobe |
| sub_i | input | 1 | 0 add, 1 subtract |
| a_i | input | W | First operand, sign-magnitude |
| b_i | input | W | Second operand, sign-magnitude |
| out_vld_o | output | 1 | Result valid |
| res_o | output | W | Result, sign-magnitude |
| ovf_o | output | 1 | Magnitude overflow |

## Verification
The bench builds the unit with W=6, which keeps the full operand space of 64 by 64 values under both operations small enough to sweep exhaustively. That sweep reaches every pair of zero encodings, every equal-magnitude cancellation and every overflow boundary at the range extremes. Each result is compared against a signed-integer model.

// File: rtl/sm_addsub_pkg.sv
package sm_addsub_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } sm_op_e;
endpackage

// File: rtl/sm_mag_cmp.sv
module sm_mag_cmp #(
    parameter int MW = 7
) (
    input  logic [MW-1:0] x_mag,
    input  logic [MW-1:0] y_mag,
    output logic          x_ge_y
);
    always_comb x_ge_y = (x_mag >= y_mag);
endmodule

// File: rtl/sm_mag_arith.sv
module sm_mag_arith #(
    parameter int MW = 7
) (
    input  logic [MW-1:0] big_mag,
    input  logic [MW-1:0] small_mag,
    input  logic          do_sub,
    output logic [MW-1:0] mag_out,
    output logic          carry_out
);
    logic [MW:0] full;
    always_comb begin
        if (do_sub) full = {1'b0, big_mag} - {1'b0, small_mag};
        else        full = {1'b0, big_mag} + {1'b0, small_mag};
        mag_out   = full[MW-1:0];
        carry_out = do_sub ? 1'b0 : full[MW];
    end
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
    import sm_addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld_i,
    input  logic         sub_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         out_vld_o,
    output logic [W-1:0] res_o,
    output logic         ovf_o
);
    localparam int MW = W - 1;

    sm_op_e        op;
    logic          a_sgn, b_sgn_eff, like_sgn, a_ge_b, carry;
    logic [MW-1:0] a_mag, b_mag, big_mag, small_mag, sum_mag;
    logic          raw_sgn, nxt_sgn, nxt_ovf;

    always_comb begin
        op        = sm_op_e'(sub_i);
        a_sgn     = a_i[W-1];
        a_mag     = a_i[MW-1:0];
        b_mag     = b_i[MW-1:0];
        b_sgn_eff = b_i[W-1] ^ (op == OP_SUB);
        like_sgn  = (a_sgn == b_sgn_eff);
    end

    sm_mag_cmp #(.MW(MW)) u_cmp (
        .x_mag  (a_mag),
        .y_mag  (b_mag),
        .x_ge_y (a_ge_b)
    );

    always_comb begin
        big_mag   = a_ge_b ? a_mag : b_mag;
        small_mag = a_ge_b ? b_mag : a_mag;
    end

    sm_mag_arith #(.MW(MW)) u_arith (
        .big_mag   (big_mag),
        .small_mag (small_mag),
        .do_sub    (!like_sgn),
        .mag_out   (sum_mag),
        .carry_out (carry)
    );

    always_comb begin
        if (like_sgn) raw_sgn = a_sgn;
        else          raw_sgn = a_ge_b ? a_sgn : b_sgn_eff;
        nxt_sgn = raw_sgn & (|sum_mag);
        nxt_ovf = like_sgn & carry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld_o <= 1'b0;
            res_o     <= '0;
            ovf_o     <= 1'b0;
        end else begin
            out_vld_o <= in_vld_i;
            if (in_vld_i) begin
                res_o <= {nxt_sgn, sum_mag};
                ovf_o <= nxt_ovf;
            end
        end
    end

    // R7
    no_negzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> !(res_o[W-1] && (res_o[MW-1:0] == '0)));

    // R3
    ovf_like_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i && (a_i[W-1] != (b_i[W-1] ^ sub_i)) |=> !ovf_o);

    // R4
    unlike_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i && (a_i[W-1] != (b_i[W-1] ^ sub_i)) |=>
            (res_o[MW-1:0] <= $past(a_i[MW-1:0])) || (res_o[MW-1:0] <= $past(b_i[MW-1:0])));

    // R8
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld_i |=> out_vld_o);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld_i |=> !out_vld_o && $stable(res_o) && $stable(ovf_o));
endmodule

// File: tb/sm_addsub_bench.sv
`timescale 1ns/1ps
module sm_addsub_bench;
    localparam int W   = 6;
    localparam int MW  = W - 1;
    localparam int MAX = (1 << MW) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_vld_i = 1'b0;
    logic         sub_i = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         out_vld_o;
    logic [W-1:0] res_o;
    logic         ovf_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [W:0] exp_q[$];
    string      tag_q[$];
    logic [W:0] last_exp;

    always #2 clk = ~clk;

    sm_addsub #(.W(W)) u_sm_addsub (
        .clk(clk), .rst_n(rst_n), .in_vld_i(in_vld_i), .sub_i(sub_i),
        .a_i(a_i), .b_i(b_i), .out_vld_o(out_vld_o), .res_o(res_o), .ovf_o(ovf_o)
    );

    // Signed-integer model: returns {sign, magnitude, overflow}
    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
        int va, vb, sum, mag_abs, m;
        logic sg, ov;
        va = a[W-1] ? -int'(a[MW-1:0]) : int'(a[MW-1:0]);
        vb = b[W-1] ? -int'(b[MW-1:0]) : int'(b[MW-1:0]);
        if (s) vb = -vb;
        sum = va + vb;
        mag_abs = (sum < 0) ? -sum : sum;
        ov = (mag_abs > MAX);
        m  = mag_abs % (MAX + 1);
        sg = (sum < 0) && (m != 0);
        return {sg, m[MW-1:0], ov};
    endfunction

    function automatic string tag_of(input logic [W-1:0] a, input logic [W-1:0] b, input logic s, input logic [W:0] e);
        if (e[MW:1] == '0) return "R7";
        if (e[0]) return "R3";
        if ((a[W-1] && a[MW-1:0] == '0) || (b[W-1] && b[MW-1:0] == '0)) return "R6";
        if (s) return "R5";
        if (a[W-1] == b[W-1]) return "R2";
        return "R4";
    endfunction

    task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
        logic [W:0] e;
        @(negedge clk);
        a_i = a; b_i = b; sub_i = s; in_vld_i = 1'b1;
        e = model(a, b, s);
        exp_q.push_back(e);
        tag_q.push_back(tag_of(a, b, s, e));
        last_exp = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld_i = 1'b0;
        end
    endtask

    task automatic check(input string tg, input logic [W:0] act, input logic [W:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tg, act, exp);
        end
    endtask

    // Monitor: pops the oldest expected item whenever a result is valid
    always @(negedge clk) begin
        if (rst_n && out_vld_o) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected result", {res_o, ovf_o}, '1);
            end else begin
                automatic logic [W:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, {res_o, ovf_o}, e);
            end
        end
    end

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset", {out_vld_o, res_o, ovf_o}, '0);
        rst_n = 1'b1;

        // R1 encoding: +3 + -1 = +2 ; -3 + +1 = -2
        send(6'b000011, 6'b100001, 1'b0);
        send(6'b100011, 6'b000001, 1'b0);
        // R6 zero encodings: -0 + -0, +0 - -0, -0 + 5, 7 - -0
        send(6'b100000, 6'b100000, 1'b0);
        send(6'b000000, 6'b100000, 1'b1);
        send(6'b100000, 6'b000101, 1'b0);
        send(6'b000111, 6'b100000, 1'b1);
        // R3 extremes: max+1, -max + -1, max - -max
        send(6'b011111, 6'b000001, 1'b0);
        send(6'b111111, 6'b100001, 1'b0);
        send(6'b011111, 6'b111111, 1'b1);
        // R7 cancellation: max - max, -max + max
        send(6'b011111, 6'b011111, 1'b1);
        send(6'b111111, 6'b011111, 1'b0);
        // R8 hold: last item then idle; result must stay put
        send(6'b000100, 6'b100110, 1'b0);
        idle(4);
        n_chk++;
        if (out_vld_o !== 1'b0 || {res_o, ovf_o} !== last_exp) begin
            n_fail++;
            $display("FAIL R8 hold: actual=%b_%h expected=0_%h", out_vld_o, {res_o, ovf_o}, last_exp);
        end

        // Exhaustive sweep: R2 R3 R4 R5 R6 R7
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < (1 << W); a++)
                for (int b = 0; b < (1 << W); b++)
                    send(W'(a), W'(b), s[0]);
        idle(4);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R8 missing results: actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule